// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the timing pulses that a serial transmitter and receiver use to pace their bits. A 16-bit phase accumulator adds a programmable increment on every enabled system clock. Each time the sum passes 2^16, the block emits an oversampling tick. The tick rate is therefore the increment divided by 65536, in ticks per clock. Every sixteenth tick also marks a bit boundary. Every tenth bit boundary marks the end of a character frame: one start bit, eight data bits and one stop bit.

The resulting bit rate is increment × f_clk / 2^20. Fractional ratios are exact on average, with a jitter of at most one clock per tick. The increment is an input that control logic drives, normally from the upper half of a control word. A new value applies from the next clock edge. When the enable input is low, the phase and both counters are held at zero. The first bit and frame after enabling are therefore timed from the enable.

Top module: `nco_baud_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `tick_o`, `bit_o` and `frame_o` are low. The phase and both counters start from zero.
- R2: At each clock edge with `en_i` high, `nco_i` is added to the 16-bit phase modulo 2^16. `tick_o` is high for the clock after every edge at which that sum reached 2^16 or more, and low otherwise.
- R3: With `nco_i` equal to zero, `tick_o`, `bit_o` and `frame_o` stay low.
- R4: `bit_o` is asserted together with every 16th tick. The first such pulse after enabling comes with the 16th tick.
- R5: `frame_o` is asserted together with every 10th `bit_o` pulse. The first such pulse after enabling comes with the 10th bit pulse.
- R6: At each clock edge with `en_i` low, the phase and both counters are cleared, and all three outputs are low in the following cycle.
- R7: A change of `nco_i` alters the step from the very next edge, and the accumulated phase is kept.
- R8: With `nco_i` = 4096 from a cleared start, a tick occurs every 16 clocks, `bit_o` every 256 clocks and `frame_o` every 2560 clocks, which is f_clk × 4096 / 2^20 bits per second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears phase and counters |
| nco_i | input | 16 | Phase increment per clock |
| tick_o | output | 1 | 16x oversampling tick, one-clock pulse |
| bit_o | output | 1 | Bit boundary strobe, one-clock pulse |
| frame_o | output | 1 | End of 10-bit frame, one-clock pulse |

## Verification
All three outputs are registered. Each is due in the cycle directly after the clock edge that sampled the enable and increment producing it, so there is exactly one cycle of latency from stimulus to pulse. The bench drives its inputs on the falling edge. A behavioural model advances at the rising edge using those same input values, and the outputs are compared with the model on the next falling edge, half a cycle after they settle. Window counts for the rate checks and the count of cycles to the first bit after re-enabling are taken over falling edges in the same way.

// File: rtl/nco_baud_gen.sv
module nco_baud_gen #(
  parameter int NCO_W      = 16,
  parameter int OVS        = 16,
  parameter int FRAME_BITS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [NCO_W-1:0] nco_i,
  output logic             tick_o,
  output logic             bit_o,
  output logic             frame_o
);
  localparam int SUB_W = $clog2(OVS);
  localparam int BIT_W = $clog2(FRAME_BITS);

  logic [NCO_W-1:0] phase_q;
  logic [SUB_W-1:0] sub_q;
  logic [BIT_W-1:0] bitn_q;
  logic [NCO_W:0]   sum;
  logic             carry, sub_wrap, bit_wrap;

  assign sum      = {1'b0, phase_q} + {1'b0, nco_i};
  assign carry    = sum[NCO_W];
  assign sub_wrap = (sub_q == SUB_W'(OVS - 1));
  assign bit_wrap = (bitn_q == BIT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      sub_q   <= '0;
      bitn_q  <= '0;
      tick_o  <= 1'b0;
      bit_o   <= 1'b0;
      frame_o <= 1'b0;
    end else if (!en_i) begin
      phase_q <= '0;
      sub_q   <= '0;
      bitn_q  <= '0;
      tick_o  <= 1'b0;
      bit_o   <= 1'b0;
      frame_o <= 1'b0;
    end else begin
      phase_q <= sum[NCO_W-1:0];
      tick_o  <= carry;
      bit_o   <= carry & sub_wrap;
      frame_o <= carry & sub_wrap & bit_wrap;
      if (carry) sub_q <= sub_wrap ? '0 : sub_q + 1'b1;
      if (carry && sub_wrap) bitn_q <= bit_wrap ? '0 : bitn_q + 1'b1;
    end
  end

  AST_BIT_WITH_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> tick_o); // R4
  AST_FRAME_WITH_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> bit_o); // R5
  AST_ZERO_STEP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(nco_i) == '0) |-> !tick_o); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (!tick_o && !bit_o && !frame_o)); // R6
  AST_BIT_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bitn_q < BIT_W'(FRAME_BITS)); // R5
endmodule

// File: tb/nco_baud_gen_bench.sv
module nco_baud_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [15:0] nco = 16'd0;
  logic tick, bitp, frame;
  int tests = 0, fails = 0;
  bit done = 1'b0;
  string ph = "R1";

  int m_phase = 0, m_sub = 0, m_bit = 0;
  bit e_tick = 0, e_bit = 0, e_frame = 0;

  always #4 clk = ~clk;

  nco_baud_gen u_nco_baud_gen (.clk_i(clk), .rst_ni(rst_n), .en_i(en), .nco_i(nco),
    .tick_o(tick), .bit_o(bitp), .frame_o(frame));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n || !en) begin
      m_phase = 0; m_sub = 0; m_bit = 0;
      e_tick = 0; e_bit = 0; e_frame = 0;
    end else begin
      int s;
      s = m_phase + int'(nco);
      e_tick = (s >= 65536);
      m_phase = s % 65536;
      e_bit = e_tick && (m_sub == 15);
      e_frame = e_bit && (m_bit == 9);
      if (e_tick) m_sub = (m_sub + 1) % 16;
      if (e_bit) m_bit = (m_bit + 1) % 10;
    end
  end

  always @(negedge clk) begin
    chk(tick == e_tick, {ph, " R2 tick"}, tick, e_tick);
    chk(bitp == e_bit, {ph, " R4 bit"}, bitp, e_bit);
    chk(frame == e_frame, {ph, " R5 frame"}, frame, e_frame);
  end

  initial begin
    int nt, nb, nf, first;
    repeat (3) @(negedge clk);
    chk(!tick && !bitp && !frame, "R1 outputs in reset", {tick, bitp, frame}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tick && !bitp && !frame, "R1 outputs after release", {tick, bitp, frame}, 0);

    ph = "R3"; en = 1'b1; nco = 16'd0; nt = 0;
    repeat (100) begin @(negedge clk); nt += tick + bitp + frame; end
    chk(nt == 0, "R3 pulses with zero step", nt, 0);

    ph = "R8"; en = 1'b0; @(negedge clk);
    en = 1'b1; nco = 16'd4096; nt = 0; nb = 0; nf = 0;
    repeat (2560) begin @(negedge clk); nt += tick; nb += bitp; nf += frame; end
    chk(nt == 160, "R8 ticks in 2560 clocks", nt, 160);
    chk(nb == 10, "R8 bits in 2560 clocks", nb, 10);
    chk(nf == 1, "R8 frames in 2560 clocks", nf, 1);
    chk(frame == 1, "R5 frame on 10th bit", frame, 1);

    ph = "R2"; nco = 16'hFFFF;
    repeat (300) @(negedge clk);
    nco = 16'h1234;
    repeat (700) @(negedge clk);

    ph = "R7"; nco = 16'h9000;
    repeat (50) @(negedge clk);
    nco = 16'h0100;
    repeat (400) @(negedge clk);

    ph = "R6"; nco = 16'hC000; en = 1'b0;
    repeat (5) begin
      @(negedge clk);
      chk(!tick && !bitp && !frame, "R6 outputs while disabled", {tick, bitp, frame}, 0);
    end
    en = 1'b1; nco = 16'd4096; first = 0;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      if (bitp && first == 0) first = i;
    end
    chk(first == 256, "R4/R6 first bit after re-enable", first, 256);

    ph = "R2"; nco = 16'h7FFF;
    repeat (3000) @(negedge clk);
    ph = "R1"; rst_n = 1'b0;
    @(negedge clk);
    chk(!tick && !bitp && !frame, "R1 outputs in mid-run reset", {tick, bitp, frame}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule